// File: doc/BRIEF.md
# Issue Stall Scoreboard

This block sits at the issue point of an in-order core whose execution side is three parallel four-stage lanes: an ALU lane and a multiply lane that advance together and retire in order, and a decoupled memory lane. For every instruction presented at issue it decides, in the same cycle, whether the instruction may go or must wait because an operand it reads will not yet be available on a forwarding path.

Every accepted instruction that writes a general register other than register 15 leaves a record holding its destination index and a count of the cycles still to go before its result can feed an ALU-stage consumer. All counts step down once per clock, stalled or not. A source operand is marked either as needed at the ALU stage or as needed one stage earlier (shifter, first multiply-accumulate stage or address adder). The early form costs one more cycle. When the block stalls, the issue stage holds the same instruction and a bubble enters the lanes. A load only delays the instructions that read its result, so younger independent work goes on without waiting for it.

Top module: `issue_interlock`

## Requirements
- R1: After reset no register is pending, so any instruction, including one with early operands, issues without a stall.
- R2: A load (class code 2) has a result latency of three. A load followed by an ALU instruction that reads the load's destination at the ALU stage takes four cycles from the load's issue to the consumer's issue.
- R3: An operand flagged early adds one cycle. A load followed by a consumer that reads its destination early takes five cycles.
- R4: An ALU instruction (class code 0) has a result latency of one. A dependent ALU-stage reader issues in the very next cycle (two cycles in total), and an early reader waits one cycle (three in total).
- R5: A multiply (class code 1) has a result latency of three, so a dependent ALU-stage reader takes four cycles in total.
- R6: When a multiply issues with its accumulator flag set, the last source slot (index 2) is its accumulator. If that operand's pending writer is itself a multiply, it causes no stall, so a multiply-accumulate chain into one register issues back to back (two cycles).
- R7: A write to register 15, or an instruction whose destination enable is low, leaves no pending record. A later reader of that register does not stall.
- R8: An instruction that neither reads nor writes a pending register issues at once, even while a load is outstanding.
- R9: A stalled instruction is held until it can issue, and pending counts keep falling during the stall. In a load, dependent ALU op, dependent ALU op chain, the third instruction issues one cycle after the second (five cycles in total).
- R10: A new writer stalls while an older pending writer of the same register still has a remaining count at least equal to the new writer's latency. A load followed by an ALU write to the same register takes four cycles.
- R11: A source slot whose enable bit is low is ignored, whatever register index it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is presented at issue |
| iss_class | input | 2 | Lane class: 0 ALU, 1 multiply, 2 load |
| iss_dst_en | input | 1 | The instruction writes a register |
| iss_dst | input | 4 | Destination register index |
| iss_src_en | input | 3 | Per-slot source enable |
| iss_src_early | input | 3 | Per-slot flag: operand needed one stage before the ALU stage |
| iss_src | input | 12 | Three 4-bit source indices, slot 0 in the low bits |
| iss_acc | input | 1 | Slot 2 is the accumulator of a multiply-accumulate |
| stall | output | 1 | Hold the presented instruction this cycle |

## Verification
A record whose count runs one too long or too short, or one left behind after it should have retired, shows up as a stall that comes one cycle too early or too late on the very next dependent instruction. The error shows at the `stall` port within the three cycles that the longest latency spans. A destination that is stored wrongly shows up either as a stall on an independent reader or as a missing stall on a true dependent. The cycle totals of short directed sequences pin the latencies to exact values. A long random stream, compared each cycle against a model that tracks the cycle in which each register becomes ready, catches errors in record replacement, in the accumulator exemption and in the write-after-write check.

// File: rtl/issue_interlock.sv
module issue_interlock #(
  parameter int RW      = 4,
  parameter int NSRC    = 3,
  parameter int NENT    = 4,
  parameter int PC_REG  = 15,
  parameter int LAT_ALU = 1,
  parameter int LAT_MUL = 3,
  parameter int LAT_LD  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_valid,
  input  logic [1:0]         iss_class,
  input  logic               iss_dst_en,
  input  logic [RW-1:0]      iss_dst,
  input  logic [NSRC-1:0]    iss_src_en,
  input  logic [NSRC-1:0]    iss_src_early,
  input  logic [NSRC*RW-1:0] iss_src,
  input  logic               iss_acc,
  output logic               stall
);

  localparam int MAXL = (LAT_ALU > LAT_MUL) ? ((LAT_ALU > LAT_LD) ? LAT_ALU : LAT_LD)
                                            : ((LAT_MUL > LAT_LD) ? LAT_MUL : LAT_LD);
  localparam int CW = $clog2(MAXL + 1);
  localparam int IW = (NENT > 1) ? $clog2(NENT) : 1;
  localparam logic [1:0] CLS_ALU = 2'd0;
  localparam logic [1:0] CLS_MUL = 2'd1;
  localparam logic [1:0] CLS_LD  = 2'd2;

  logic [NENT-1:0] val_q;
  logic [NENT-1:0] mul_q;
  logic [RW-1:0]   dst_q [NENT];
  logic [CW-1:0]   cnt_q [NENT];

  logic [CW-1:0]   lat_new;
  logic            trk;
  logic [NENT-1:0] hit;
  logic            any_free;
  logic [IW-1:0]   alloc_idx;
  logic            fire;

  always_comb begin
    case (iss_class)
      CLS_MUL: lat_new = CW'(LAT_MUL);
      CLS_LD:  lat_new = CW'(LAT_LD);
      default: lat_new = CW'(LAT_ALU);
    endcase
  end

  assign trk = iss_dst_en && (iss_dst != RW'(PC_REG));

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    logic src_dep;
    logic waw;
    always_comb begin
      src_dep = 1'b0;
      for (int j = 0; j < NSRC; j++) begin
        if (iss_src_en[j] && iss_src[j*RW +: RW] == dst_q[i] &&
            (iss_src_early[j] || cnt_q[i] != '0) &&
            !(j == NSRC-1 && iss_acc && iss_class == CLS_MUL && mul_q[i]))
          src_dep = 1'b1;
      end
    end
    assign waw    = trk && dst_q[i] == iss_dst && cnt_q[i] >= lat_new;
    assign hit[i] = val_q[i] && (src_dep || waw);
  end

  always_comb begin
    any_free  = 1'b0;
    alloc_idx = '0;
    for (int i = NENT-1; i >= 0; i--) begin
      if (!val_q[i]) begin
        any_free  = 1'b1;
        alloc_idx = IW'(i);
      end
    end
  end

  assign stall = iss_valid && ((|hit) || (trk && !any_free));
  assign fire  = iss_valid && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      mul_q <= '0;
      for (int i = 0; i < NENT; i++) begin
        dst_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NENT; i++) begin
        if (fire && trk && alloc_idx == IW'(i)) begin
          val_q[i] <= 1'b1;
          mul_q[i] <= (iss_class == CLS_MUL);
          dst_q[i] <= iss_dst;
          cnt_q[i] <= lat_new - CW'(1);
        end else if (fire && trk && val_q[i] && dst_q[i] == iss_dst) begin
          val_q[i] <= 1'b0;
        end else if (val_q[i]) begin
          if (cnt_q[i] == '0) val_q[i] <= 1'b0;
          else cnt_q[i] <= cnt_q[i] - CW'(1);
        end
      end
    end
  end

  for (genvar i = 0; i < NENT; i++) begin : g_chk
    a_r7_pc_untracked: assert property (@(posedge clk) disable iff (!rst_n)
      val_q[i] |-> dst_q[i] != RW'(PC_REG));
    a_r9_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (val_q[i] && cnt_q[i] != '0) |=> (!val_q[i] || cnt_q[i] == $past(cnt_q[i]) - CW'(1)));
  end

  a_r2_load_blocks_next: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && iss_class == CLS_LD && trk) |=>
      (!(iss_valid && iss_src_en[0] && !iss_src_early[0] && iss_src[RW-1:0] == $past(iss_dst)) || stall));

  a_r8_independent_free: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_src_en == '0 && !iss_dst_en) |-> !stall);

  a_r6_mac_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && iss_class == CLS_MUL && trk) |=>
      (!(iss_valid && iss_class == CLS_MUL && iss_acc && !iss_dst_en &&
         iss_src_en == NSRC'(1) << (NSRC-1) && !iss_src_early[NSRC-1] &&
         iss_src[(NSRC-1)*RW +: RW] == $past(iss_dst)) || !stall));

endmodule

// File: tb/issue_interlock_test.sv
`timescale 1ns/1ps
module issue_interlock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [1:0]  iss_class = 2'd0;
  logic        iss_dst_en = 1'b0;
  logic [3:0]  iss_dst = 4'd0;
  logic [2:0]  iss_src_en = 3'd0;
  logic [2:0]  iss_src_early = 3'd0;
  logic [11:0] iss_src = 12'd0;
  logic        iss_acc = 1'b0;
  logic        stall;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int ready_n [16];
  bit is_mul [16];

  issue_interlock uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
    .iss_dst_en(iss_dst_en), .iss_dst(iss_dst), .iss_src_en(iss_src_en),
    .iss_src_early(iss_src_early), .iss_src(iss_src), .iss_acc(iss_acc), .stall(stall)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lat_of(input logic [1:0] c);
    return (c == 2'd1) ? 3 : (c == 2'd2) ? 3 : 1;
  endfunction

  function automatic bit exp_stall();
    bit d = 0;
    if (!iss_valid) return 0;
    for (int j = 0; j < 3; j++) begin
      int r = int'(iss_src[j*4 +: 4]);
      if (!iss_src_en[j]) continue;
      if (j == 2 && iss_acc && iss_class == 2'd1 && is_mul[r] && cyc <= ready_n[r]) continue;
      if (iss_src_early[j] ? (cyc <= ready_n[r]) : (cyc < ready_n[r])) d = 1;
    end
    if (iss_dst_en && iss_dst != 4'd15 && ready_n[iss_dst] - cyc >= lat_of(iss_class)) d = 1;
    return d;
  endfunction

  task automatic step(input string tag, input logic v, input logic [1:0] c, input logic de,
                      input logic [3:0] d, input logic [2:0] se, input logic [2:0] ea,
                      input logic [11:0] s, input logic acc, output logic st);
    bit e;
    @(negedge clk);
    iss_valid = v; iss_class = c; iss_dst_en = de; iss_dst = d;
    iss_src_en = se; iss_src_early = ea; iss_src = s; iss_acc = acc;
    #1;
    e = exp_stall();
    checks++;
    if (stall !== e) begin
      failures++;
      $display("FAIL %s: cycle %0d stall=%b expected=%b", tag, cyc, stall, e);
    end
    st = stall;
    if (v && !e && de && d != 4'd15) begin
      ready_n[d] = cyc + lat_of(c);
      is_mul[d] = (c == 2'd1);
    end
  endtask

  task automatic idle(input int n);
    logic st;
    for (int k = 0; k < n; k++) step("idle", 0, 0, 0, 0, 0, 0, 0, 0, st);
  endtask

  task automatic issue(input string tag, input logic [1:0] c, input logic de, input logic [3:0] d,
                       input logic [2:0] se, input logic [2:0] ea, input logic [11:0] s,
                       input logic acc, output int n);
    logic st;
    n = 0;
    do begin
      step(tag, 1, c, de, d, se, ea, s, acc, st);
      n++;
    end while (st && n < 20);
  endtask

  task automatic expect_total(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: total cycles=%0d expected=%0d", tag, got, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: run did not end, checks=%0d", checks);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int a, b, c2;
    logic st;
    void'($urandom(32'd1234));
    for (int r = 0; r < 16; r++) begin ready_n[r] = -100; is_mul[r] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: nothing pending after reset, early operands issue at once
    issue("R1", 2'd0, 1, 4'd4, 3'b011, 3'b011, {4'd0, 4'd3, 4'd1}, 0, a);
    expect_total("R1", a, 1);
    idle(4);

    // R2: load then ALU-stage reader, four cycles
    issue("R2", 2'd2, 1, 4'd1, 3'b000, 3'b000, 12'd0, 0, a);
    issue("R2", 2'd0, 1, 4'd3, 3'b011, 3'b000, {4'd0, 4'd1, 4'd3}, 0, b);
    expect_total("R2", a + b, 4);
    idle(4);

    // R3: load then early reader, five cycles
    issue("R3", 2'd2, 1, 4'd1, 3'b000, 3'b000, 12'd0, 0, a);
    issue("R3", 2'd0, 1, 4'd3, 3'b011, 3'b010, {4'd0, 4'd1, 4'd3}, 0, b);
    expect_total("R3", a + b, 5);
    idle(4);

    // R4: ALU latency one, normal and early readers
    issue("R4", 2'd0, 1, 4'd2, 3'b000, 3'b000, 12'd0, 0, a);
    issue("R4", 2'd0, 1, 4'd3, 3'b001, 3'b000, {8'd0, 4'd2}, 0, b);
    expect_total("R4", a + b, 2);
    idle(4);
    issue("R4", 2'd0, 1, 4'd2, 3'b000, 3'b000, 12'd0, 0, a);
    issue("R4", 2'd0, 1, 4'd3, 3'b001, 3'b001, {8'd0, 4'd2}, 0, b);
    expect_total("R4", a + b, 3);
    idle(4);

    // R5: multiply latency three
    issue("R5", 2'd1, 1, 4'd5, 3'b000, 3'b000, 12'd0, 0, a);
    issue("R5", 2'd0, 1, 4'd6, 3'b001, 3'b000, {8'd0, 4'd5}, 0, b);
    expect_total("R5", a + b, 4);
    idle(4);

    // R6: accumulate chain into the same register
    issue("R6", 2'd1, 1, 4'd6, 3'b000, 3'b000, 12'd0, 0, a);
    issue("R6", 2'd1, 1, 4'd6, 3'b100, 3'b000, {4'd6, 8'd0}, 1, b);
    expect_total("R6", a + b, 2);
    issue("R6", 2'd1, 1, 4'd6, 3'b100, 3'b000, {4'd6, 8'd0}, 1, c2);
    expect_total("R6", c2, 1);
    idle(4);

    // R7: register 15 and disabled destinations are not tracked
    issue("R7", 2'd2, 1, 4'd15, 3'b000, 3'b000, 12'd0, 0, a);
    issue("R7", 2'd0, 1, 4'd3, 3'b001, 3'b001, {8'd0, 4'd15}, 0, b);
    expect_total("R7", a + b, 2);
    idle(4);
    issue("R7", 2'd2, 0, 4'd7, 3'b000, 3'b000, 12'd0, 0, a);
    issue("R7", 2'd0, 1, 4'd3, 3'b001, 3'b001, {8'd0, 4'd7}, 0, b);
    expect_total("R7", a + b, 2);
    idle(4);

    // R8: independent work proceeds past an outstanding load
    issue("R8", 2'd2, 1, 4'd1, 3'b000, 3'b000, 12'd0, 0, a);
    issue("R8", 2'd0, 1, 4'd8, 3'b001, 3'b000, {8'd0, 4'd9}, 0, b);
    issue("R8", 2'd1, 1, 4'd10, 3'b011, 3'b000, {4'd0, 4'd8, 4'd9}, 0, c2);
    expect_total("R8", a + b + c2, 3);
    idle(4);

    // R9: stall holds, counts keep falling, chained reader follows at once
    issue("R9", 2'd2, 1, 4'd1, 3'b000, 3'b000, 12'd0, 0, a);
    issue("R9", 2'd0, 1, 4'd2, 3'b001, 3'b000, {8'd0, 4'd1}, 0, b);
    issue("R9", 2'd0, 1, 4'd3, 3'b001, 3'b000, {8'd0, 4'd2}, 0, c2);
    expect_total("R9", a + b + c2, 5);
    idle(4);

    // R10: write-after-write ordering
    issue("R10", 2'd2, 1, 4'd1, 3'b000, 3'b000, 12'd0, 0, a);
    issue("R10", 2'd0, 1, 4'd1, 3'b000, 3'b000, 12'd0, 0, b);
    expect_total("R10", a + b, 4);
    idle(4);

    // R11: disabled source slots carry a pending index but are ignored
    issue("R11", 2'd2, 1, 4'd1, 3'b000, 3'b000, 12'd0, 0, a);
    issue("R11", 2'd0, 1, 4'd3, 3'b000, 3'b111, {4'd1, 4'd1, 4'd1}, 0, b);
    expect_total("R11", a + b, 2);
    idle(4);

    // random stream checked every cycle against the ready-cycle model (R2-R11)
    begin
      logic v; logic [1:0] c; logic de; logic [3:0] d; logic [2:0] se, ea; logic [11:0] s; logic acc;
      st = 0; v = 0; c = 0; de = 0; d = 0; se = 0; ea = 0; s = 0; acc = 0;
      for (int k = 0; k < 4000; k++) begin
        if (!st) begin
          v   = ($urandom % 5) != 0;
          c   = 2'($urandom % 3);
          de  = ($urandom % 4) != 0;
          d   = 4'($urandom % 8 + (($urandom % 16 == 0) ? 8 : 0));
          se  = 3'($urandom);
          ea  = 3'($urandom) & 3'($urandom);
          s   = {4'($urandom % 8), 4'($urandom % 8), 4'($urandom % 8)};
          acc = c == 2'd1 && ($urandom % 2);
          if (acc) begin s[11:8] = d; se[2] = 1'b1; end
        end
        step("R9-random", v, c, de, d, se, ea, s, acc, st);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule